// File: doc/BRIEF.md
# Converter Result Port with Shared Parallel/Serial Pins

This block hands a 16-bit converter result to a host over one set of data pins that can act either as a parallel bus or as a serial port. A strobe loads each new result. A mode input picks how the pins behave. In parallel mode all sixteen pins drive the word, and the upper and lower bytes can be exchanged. In serial mode three of the pins act as serial clock in, serial data in and serial data out, and the other pins stop driving. A format input selects offset binary or two's complement coding, and the choice applies to both modes.

The serial clock comes from the host and is slow compared with the system clock. The block passes it through a synchronizer and finds its edges. Each rising edge presents the next bit, MSB first, so the host can sample it on the falling edge. On each falling edge the serial data input is shifted into the bottom of the register. A result from a device further up a chain therefore follows the local word on the same line, sixteen serial clocks later. Every pin has its own output-enable, so pad behaviour can be checked without pad models.

Top module: `adc_result_port`

## Requirements
- R1: While reset is active and after it, with the mode input low, every pin is enabled (`pad_oe` = 16'hFFFF) and `pad_out` is 16'h0000 until the first load.
- R2: With `mode_serial` low, every output-enable is 1. One clock edge after a cycle with `res_valid` high, `pad_out` carries the formatted result.
- R3: With `fmt_offset` high when the result is loaded, the word is passed unchanged (offset binary). With it low, bit 15 is inverted (two's complement). This applies to both modes.
- R4: With `swap_bytes` high when the result is loaded, the parallel bus carries the formatted low byte on bits 15:8 and the formatted high byte on bits 7:0. With it low, bit 15 is the MSB.
- R5: The parallel bus changes only on a load. Changes on `res_data`, `fmt_offset` or `swap_bytes` without `res_valid` leave `pad_out` unchanged.
- R6: With `mode_serial` high, only bit 10 (serial data out) is enabled (`pad_oe` = 16'h0400), and every other bit of `pad_out` is 0.
- R7: In serial mode the k-th rising edge of the serial clock after a load (k = 1..16) puts bit 16-k of the formatted word on `pad_out[10]`. The bit holds until the next rising edge.
- R8: The level of `pad_sdi_in` at the i-th falling serial-clock edge after a load appears on `pad_out[10]` after rising edge 16+i.
- R9: A load in the middle of a serial read restarts the sequence: the next rising edge presents the MSB of the new word.
- R10: The byte exchange does not apply to the serial stream. The serial output is always the formatted word, MSB first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| res_valid | input | 1 | Strobe that loads a new conversion result |
| res_data | input | 16 | Raw result in offset binary |
| mode_serial | input | 1 | 1 = serial pin roles, 0 = parallel bus |
| fmt_offset | input | 1 | 1 = offset binary, 0 = two's complement (sampled at load) |
| swap_bytes | input | 1 | 1 = exchange bytes on the parallel bus (sampled at load) |
| pad_sck_in | input | 1 | Input buffer of pin 11: serial clock from the host |
| pad_sdi_in | input | 1 | Input buffer of pin 9: serial chain input |
| pad_out | output | 16 | Pin output values |
| pad_oe | output | 16 | Per-pin output enables, 1 = driving |

## Verification
The hardest case to reach from the ports is the chained part of a serial read. It needs a load, then sixteen full serial-clock periods, and only then do bits captured from `pad_sdi_in` emerge, each offset by exactly sixteen edges. The bench runs full reads of 16 + n periods with random chain bits and a random format, and checks every rising edge against a predicted bit stream. It also fires a second load partway through a read to show that the stream restarts at the MSB.

// File: rtl/adc_port_pkg.sv
// Package: shared constants for the converter result port.
// Assumes a word of even width so that it splits into two equal halves.
package adc_port_pkg;
    localparam int WORD_W      = 16;
    localparam int SDI_PIN     = 9;
    localparam int SDO_PIN     = 10;
    localparam int SCK_PIN     = 11;
    localparam int SYNC_DEPTH  = 2;
endpackage

// File: rtl/port_formatter.sv
// Module: port_formatter
// Combinational coding of a raw result. It selects offset binary or
// two's complement (MSB inverted) and builds a byte-exchanged copy for
// the parallel bus. Assumes W is even.
module port_formatter #(
    parameter int W = 16
) (
    input  logic [W-1:0] raw,
    input  logic         offset_bin,
    input  logic         swap_half,
    output logic [W-1:0] ser_word,
    output logic [W-1:0] par_word
);
    localparam int HALF = W / 2;

    logic [W-1:0] coded;
    logic [W-1:0] swapped;

    // Invert the MSB when two's complement is requested.
    always_comb begin
        coded        = raw;
        coded[W-1]   = raw[W-1] ^ ~offset_bin;
    end

    // Exchange the upper and lower halves, bit by bit.
    for (genvar b = 0; b < W; b++) begin : g_swap
        if (b < HALF) begin : g_lo
            assign swapped[b] = coded[b + HALF];
        end else begin : g_hi
            assign swapped[b] = coded[b - HALF];
        end
    end

    // The serial path never swaps; the parallel path follows the select.
    always_comb begin
        ser_word = coded;
        par_word = swap_half ? swapped : coded;
    end
endmodule

// File: rtl/serial_shifter.sv
// Module: serial_shifter
// Shift register for serial read-out. The host clock and chain input
// are synchronized to clk, and the host clock's edges are found.
// Rising edge: present the register MSB on sdo.
// Falling edge: shift left and take the chain input into the LSB.
// Assumes the host clock is much slower than clk and SYNC >= 2.
module serial_shifter #(
    parameter int W    = 16,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         sck_pin,
    input  logic         sdi_pin,
    output logic         sdo
);
    logic [SYNC-1:0] sck_sync;
    logic [SYNC-1:0] sdi_sync;
    logic            sck_last;
    logic [W-1:0]    shreg;
    logic            sck_now;
    logic            sdi_now;
    logic            sck_rise;
    logic            sck_fall;

    // Bring the host clock and chain input into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sync <= '0;
            sdi_sync <= '0;
            sck_last <= 1'b0;
        end else begin
            sck_sync <= {sck_sync[SYNC-2:0], sck_pin};
            sdi_sync <= {sdi_sync[SYNC-2:0], sdi_pin};
            sck_last <= sck_sync[SYNC-1];
        end
    end

    // Edge detection on the synchronized host clock.
    always_comb begin
        sck_now  = sck_sync[SYNC-1];
        sdi_now  = sdi_sync[SYNC-1];
        sck_rise = sck_now & ~sck_last;
        sck_fall = ~sck_now & sck_last;
    end

    // A load wins over a shift and starts a new read sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= load_word;
        end else if (sck_fall) begin
            shreg <= {shreg[W-2:0], sdi_now};
        end
    end

    // The output bit moves only on a rising host-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo <= 1'b0;
        end else if (sck_rise) begin
            sdo <= shreg[W-1];
        end
    end
endmodule

// File: rtl/pad_driver.sv
// Module: pad_driver
// Holds the parallel word between loads. Drives per-pin values and
// enables for the selected mode. In serial mode only the data-out pin
// drives; all other pins are released and their values forced to 0.
module pad_driver #(
    parameter int W       = 16,
    parameter int SDO_BIT = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] par_word,
    input  logic         serial_mode,
    input  logic         sdo,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    logic [W-1:0] par_q;

    // The parallel word changes only when a new result is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q <= '0;
        end else if (load) begin
            par_q <= par_word;
        end
    end

    // Per-pin selection between the parallel bus and the serial role.
    for (genvar b = 0; b < W; b++) begin : g_pin
        if (b == SDO_BIT) begin : g_sdo
            assign pad_oe[b]  = 1'b1;
            assign pad_out[b] = serial_mode ? sdo : par_q[b];
        end else begin : g_plain
            assign pad_oe[b]  = ~serial_mode;
            assign pad_out[b] = serial_mode ? 1'b0 : par_q[b];
        end
    end
endmodule

// File: rtl/adc_result_port.sv
// Module: adc_result_port (top)
// Presents a conversion result on shared pins, as a parallel bus or as
// a chainable serial port. Format and byte exchange are sampled at load.
// Assumes the host serial clock is slow compared with clk.
module adc_result_port #(
    parameter int W        = adc_port_pkg::WORD_W,
    parameter int SYNC     = adc_port_pkg::SYNC_DEPTH,
    parameter int SDO_BIT  = adc_port_pkg::SDO_PIN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         res_valid,
    input  logic [W-1:0] res_data,
    input  logic         mode_serial,
    input  logic         fmt_offset,
    input  logic         swap_bytes,
    input  logic         pad_sck_in,
    input  logic         pad_sdi_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    logic [W-1:0] ser_word;
    logic [W-1:0] par_word;
    logic         sdo;

    port_formatter #(.W(W)) u_fmt (
        .raw        (res_data),
        .offset_bin (fmt_offset),
        .swap_half  (swap_bytes),
        .ser_word   (ser_word),
        .par_word   (par_word)
    );

    serial_shifter #(.W(W), .SYNC(SYNC)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (res_valid),
        .load_word (ser_word),
        .sck_pin   (pad_sck_in),
        .sdi_pin   (pad_sdi_in),
        .sdo       (sdo)
    );

    pad_driver #(.W(W), .SDO_BIT(SDO_BIT)) u_pads (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (res_valid),
        .par_word    (par_word),
        .serial_mode (mode_serial),
        .sdo         (sdo),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe)
    );
endmodule

// File: rtl/adc_result_port_chk.sv
// Module: adc_result_port_chk
// Port-level properties of the result port, bound to the top module.
module adc_result_port_chk #(
    parameter int W       = 16,
    parameter int SYNC    = 2,
    parameter int SDO_BIT = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         res_valid,
    input logic [W-1:0] res_data,
    input logic         mode_serial,
    input logic         fmt_offset,
    input logic         swap_bytes,
    input logic         pad_sck_in,
    input logic         pad_sdi_in,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_oe
);
    localparam logic [W-1:0] SER_MASK = {{(W-1){1'b0}}, 1'b1} << SDO_BIT;
    localparam int HALF = W / 2;

    logic       sck_prev;
    logic [7:0] sck_calm;

    // Expected parallel word, computed independently of the design.
    function automatic logic [W-1:0] exp_par(input logic [W-1:0] d,
                                             input logic ob, input logic sw);
        logic [W-1:0] c;
        c = ob ? d : (d ^ SER_MASK_MSB());
        return sw ? {c[HALF-1:0], c[W-1:HALF]} : c;
    endfunction

    function automatic logic [W-1:0] SER_MASK_MSB();
        return {1'b1, {(W-1){1'b0}}};
    endfunction

    // Counts cycles since the serial clock pin last changed level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            sck_calm <= '0;
        end else begin
            sck_prev <= pad_sck_in;
            if (pad_sck_in != sck_prev) sck_calm <= '0;
            else if (sck_calm != 8'hFF) sck_calm <= sck_calm + 8'd1;
        end
    end

    p_par_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_serial |-> (pad_oe == '1));

    p_ser_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_serial |-> (pad_oe == SER_MASK));

    p_ser_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_serial |-> ((pad_out & ~SER_MASK) == '0));

    // R3 and R4: the loaded word is coded and exchanged as sampled at load.
    p_load_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(res_valid) && !mode_serial) |->
        (pad_out == exp_par($past(res_data), $past(fmt_offset), $past(swap_bytes))));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(res_valid) && !mode_serial && !$past(mode_serial)) |->
        $stable(pad_out));

    // R7: serial out moves only after a host clock edge has propagated.
    p_sdo_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_serial && $past(mode_serial) && (int'(sck_calm) >= SYNC + 3)) |->
        $stable(pad_out[SDO_BIT]));

    // Inputs that no property above uses are still part of the bound port list.
    logic unused_ok;
    assign unused_ok = pad_sdi_in;
endmodule

bind adc_result_port adc_result_port_chk #(.W(W), .SYNC(SYNC), .SDO_BIT(SDO_BIT)) u_chk (.*);

// File: tb/adc_result_port_tb.sv
module adc_result_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic        mode_serial = 1'b0;
    logic        fmt_offset = 1'b1;
    logic        swap_bytes = 1'b0;
    logic        pad_sck_in = 1'b0;
    logic        pad_sdi_in = 1'b0;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    adc_result_port u_dut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .mode_serial(mode_serial), .fmt_offset(fmt_offset), .swap_bytes(swap_bytes),
        .pad_sck_in(pad_sck_in), .pad_sdi_in(pad_sdi_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [15:0] coded(input logic [15:0] d, input logic ob);
        return ob ? d : {~d[15], d[14:0]};
    endfunction

    function automatic logic [15:0] par_exp(input logic [15:0] d, input logic ob, input logic sw);
        logic [15:0] c;
        c = coded(d, ob);
        return sw ? {c[7:0], c[15:8]} : c;
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic load(input logic [15:0] d, input logic ob, input logic sw);
        @(negedge clk);
        res_data = d; fmt_offset = ob; swap_bytes = sw; res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    // One host serial clock period; returns the bit seen while clock is high.
    task automatic sck_period(input logic sdi_b, output logic got);
        @(negedge clk);
        pad_sck_in = 1'b1; pad_sdi_in = sdi_b;
        repeat (8) @(negedge clk);
        got = pad_out[10];
        pad_sck_in = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic serial_read(input logic [15:0] d, input logic ob, input int nchain);
        logic [31:0] chain;
        logic        got;
        logic        exp;
        chain = $urandom;
        load(d, ob, $urandom_range(0, 1));
        check("R6 serial enables", pad_oe, 16'h0400);
        for (int k = 1; k <= 16 + nchain; k++) begin
            sck_period(chain[k-1], got);
            exp = (k <= 16) ? coded(d, ob)[16-k] : chain[k-17];
            if (k <= 16) check("R7/R10 serial bit", {15'd0, got}, {15'd0, exp});
            else         check("R8 chained bit", {15'd0, got}, {15'd0, exp});
        end
        check("R6 idle pins zero", pad_out & 16'hFBFF, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic        got;
        logic [15:0] d;
        logic        ob;
        logic        sw;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check("R1 reset out", pad_out, 16'h0000);
        check("R1 reset oe", pad_oe, 16'hFFFF);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after reset out", pad_out, 16'h0000);

        // Directed format and swap corners.
        load(16'h8000, 1'b1, 1'b0); check("R3 offset 8000", pad_out, 16'h8000);
        load(16'h8000, 1'b0, 1'b0); check("R3 twos 8000", pad_out, 16'h0000);
        load(16'h0000, 1'b0, 1'b0); check("R3 twos 0000", pad_out, 16'h8000);
        load(16'hFFFF, 1'b0, 1'b1); check("R4 swap FFFF twos", pad_out, 16'hFF7F);
        load(16'h12AB, 1'b1, 1'b1); check("R4 swap 12AB", pad_out, 16'hAB12);
        check("R2 parallel oe", pad_oe, 16'hFFFF);

        // R5: input changes without a strobe leave the bus alone.
        @(negedge clk);
        res_data = 16'h5555; fmt_offset = 1'b0; swap_bytes = 1'b0;
        repeat (4) @(negedge clk);
        check("R5 hold", pad_out, 16'hAB12);

        // Random parallel loads.
        for (int i = 0; i < 40; i++) begin
            d = 16'($urandom); ob = 1'($urandom); sw = 1'($urandom);
            load(d, ob, sw);
            check("R2/R3/R4 parallel", pad_out, par_exp(d, ob, sw));
        end

        // Serial mode.
        @(negedge clk); mode_serial = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 enables", pad_oe, 16'h0400);
        serial_read(16'hA5C3, 1'b1, 16);
        serial_read(16'h0001, 1'b0, 8);
        for (int i = 0; i < 10; i++)
            serial_read(16'($urandom), 1'($urandom), $urandom_range(1, 16));

        // R9: reload partway through a read.
        load(16'h0F0F, 1'b1, 1'b0);
        for (int k = 0; k < 5; k++) sck_period(1'b0, got);
        load(16'hF00D, 1'b1, 1'b0);
        sck_period(1'b0, got);
        check("R9 restart MSB", {15'd0, got}, 16'd1);
        sck_period(1'b0, got);
        check("R9 second bit", {15'd0, got}, 16'd1);

        // Back to parallel: the last loaded word appears.
        @(negedge clk); mode_serial = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 return to parallel", pad_out, 16'hF00D);
        check("R2 oe after return", pad_oe, 16'hFFFF);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule